// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block gives a byte-wide, asynchronous-SRAM-style bus (15-bit address, active-low chip enable, output enable and write enable, 8-bit data) whose top eight addresses are real-time-clock registers. All other addresses reach ordinary storage. A stand-in array of `RAM_DEPTH` bytes is indexed by the low address bits, so addresses alias modulo that depth. The clock keeps a 24-hour packed-BCD calendar: seconds, minutes, hours, day of week, date, month and two-digit year. It steps on a single-cycle one-hertz enable and corrects month lengths and leap years by itself.

The bus never touches the running counters directly. Reads come from a holding copy, which follows the counters one cycle behind, so a whole calendar step shows up at once. A control register can freeze that copy for a coherent multi-byte read. It can also stage new values in the copy and load them into the counters in one cycle. The bus pins are sampled in the system clock domain. A write completes on the clock edge after write enable or chip enable goes back high. While the power-good input is low, the device is deselected.

Top module: `bcdRtcRam`

## Requirements
- R1: Addresses below 0x7FF8 behave as read/write storage. A write takes the last data and address seen while chip enable and write enable were both low, and it completes when either of them rises.
- R2: Addresses 0x7FF8..0x7FFF select clock registers by the low three address bits: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. The control register reads back its bits 7 and 6, and its other bits read as zero.
- R3: The counters change only on a cycle where the tick input is high. Seconds count 00..59 and then wrap to 00, carrying into minutes. Minutes wrap 59 to 00 in the same way, carrying into hours.
- R4: Hours count 00..23. A carry out of 23 wraps hours to 00, advances the date, and steps day of week 1..7, with 7 wrapping to 1.
- R5: Months 04, 06, 09 and 11 end after date 30. All other months except 02 end after date 31. At a month's end the date wraps to 01 and the month advances.
- R6: February ends after 29 when the year value is divisible by four (including 00), and after 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: Clock-register reads return the holding copy. That copy loads the counters on every edge while tracking is enabled. A read in the same cycle as a tick returns the value from before the tick, and the next cycle returns the stepped value.
- R8: Control bit 7 set stops the holding copy from tracking, so reads keep returning the snapshot while the counters keep running. Clearing the bit resumes tracking.
- R9: With control bit 6 set, writes to registers 1..7 land in the holding copy. A control write that takes bit 6 from 1 to 0 loads the whole copy into the counters, and this load wins over a tick in the same cycle. With bits 6 and 7 both clear, a time-register write has no lasting effect.
- R10: While power-good is low, the data-out enable is 0, the data output is 0x00, and writes to storage and to the clock registers are ignored.
- R11: Data is driven, with the data-out enable high, only when chip enable and output enable are low and write enable is high. Write enable low overrides output enable.
- R12: After reset, the time is 00:00:00, day 1, date 01, month 01, year 00, and the control register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle enable that advances the calendar |
| powerGood | input | 1 | High when the supply is in tolerance; low deselects the device |
| addr | input | 15 | Byte address |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, 0x00 when not driven |
| dataOe | output | 1 | High while the block drives read data |

## Verification
The assertions assume that the bus pins change only between clock edges and that the tick is a single-cycle pulse. They also assume that every counter load comes from a holding copy holding valid BCD, so the rollover properties only reason about legal calendar values. The stimulus keeps to these limits. Every pin change happens on the falling clock edge, each tick is raised for exactly one cycle, and new times are loaded only through the staged-write sequence with in-range BCD values. Power-good is dropped only while the bus is idle and restored only once the pins have returned high.

// File: rtl/rtcPkg.sv
`timescale 1ns/1ps
package rtcPkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } calTime_t;

  typedef struct packed {
    logic       ramWe;
    logic       holdWe;
    logic       loadCnt;
    logic       trackEn;
    logic [2:0] regIdx;
  } ctrlStrobes_t;

  localparam calTime_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                     day: 8'h01, hour: 8'h00, min: 8'h00,
                                     sec: 8'h00};

  localparam int FREEZE_BIT = 7;
  localparam int STAGE_BIT  = 6;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtcBusCtrl.sv
`timescale 1ns/1ps
module rtcBusCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              weN,
  input  logic [7:0]        dataIn,
  output ctrlStrobes_t      strobes,
  output logic [7:0]        wrData,
  output logic [RAM_AW-1:0] wrAddrLow,
  output logic [7:0]        ctrlReg
);

  logic              wrActive, prevWr, wrDone, capRtc, ctrlWe;
  logic [ADDR_W-1:0] capAddr;
  logic [7:0]        capData;
  logic              freezeBit, stageBit;

  assign wrActive = !ceN && !weN && powerGood;
  assign wrDone   = prevWr && !wrActive && powerGood;
  assign capRtc   = &capAddr[ADDR_W-1:3];
  assign ctrlWe   = wrDone && capRtc && (capAddr[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWr    <= 1'b0;
      capAddr   <= '0;
      capData   <= '0;
      freezeBit <= 1'b0;
      stageBit  <= 1'b0;
    end else begin
      prevWr <= wrActive;
      if (wrActive) begin
        capAddr <= addr;
        capData <= dataIn;
      end
      if (ctrlWe) begin
        freezeBit <= capData[FREEZE_BIT];
        stageBit  <= capData[STAGE_BIT];
      end
    end
  end

  always_comb begin
    strobes.ramWe   = wrDone && !capRtc;
    strobes.holdWe  = wrDone && capRtc && (capAddr[2:0] != 3'd0);
    strobes.loadCnt = ctrlWe && stageBit && !capData[STAGE_BIT];
    strobes.trackEn = !freezeBit && !stageBit;
    strobes.regIdx  = capAddr[2:0];
  end

  assign wrData    = capData;
  assign wrAddrLow = capAddr[RAM_AW-1:0];
  assign ctrlReg   = {freezeBit, stageBit, 6'd0};

endmodule

// File: rtl/rtcTimeCore.sv
`timescale 1ns/1ps
module rtcTimeCore
  import rtcPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick1Hz,
  input  ctrlStrobes_t strobes,
  input  logic [7:0]   wrData,
  output calTime_t     liveTime,
  output calTime_t     heldTime
);

  calTime_t   nextTime;
  logic [7:0] yearBin, lastDay;
  logic       leapYear, secWrap, minWrap, hourWrap, dateWrap, monthWrap;
  logic       minStep, hourStep, dayStep, monthStep;

  assign yearBin  = ({4'd0, liveTime.year[7:4]} * 8'd10) + {4'd0, liveTime.year[3:0]};
  assign leapYear = (yearBin[1:0] == 2'd0);

  always_comb begin
    case (liveTime.month)
      8'h02:                      lastDay = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  assign secWrap   = (liveTime.sec == 8'h59);
  assign minWrap   = (liveTime.min == 8'h59);
  assign hourWrap  = (liveTime.hour == 8'h23);
  assign dateWrap  = (liveTime.date == lastDay);
  assign monthWrap = (liveTime.month == 8'h12);

  assign minStep   = secWrap;
  assign hourStep  = minStep && minWrap;
  assign dayStep   = hourStep && hourWrap;
  assign monthStep = dayStep && dateWrap;

  always_comb begin
    nextTime = liveTime;
    nextTime.sec = secWrap ? 8'h00 : bcdInc(liveTime.sec);
    if (minStep)  nextTime.min  = minWrap ? 8'h00 : bcdInc(liveTime.min);
    if (hourStep) nextTime.hour = hourWrap ? 8'h00 : bcdInc(liveTime.hour);
    if (dayStep) begin
      nextTime.day  = (liveTime.day == 8'h07) ? 8'h01 : bcdInc(liveTime.day);
      nextTime.date = dateWrap ? 8'h01 : bcdInc(liveTime.date);
    end
    if (monthStep) begin
      nextTime.month = monthWrap ? 8'h01 : bcdInc(liveTime.month);
      if (monthWrap)
        nextTime.year = (liveTime.year == 8'h99) ? 8'h00 : bcdInc(liveTime.year);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                liveTime <= CAL_RESET;
    else if (strobes.loadCnt) liveTime <= heldTime;
    else if (tick1Hz)         liveTime <= nextTime;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldTime <= CAL_RESET;
    end else if (strobes.holdWe) begin
      case (strobes.regIdx)
        3'd1:    heldTime.sec   <= wrData;
        3'd2:    heldTime.min   <= wrData;
        3'd3:    heldTime.hour  <= wrData;
        3'd4:    heldTime.day   <= wrData;
        3'd5:    heldTime.date  <= wrData;
        3'd6:    heldTime.month <= wrData;
        default: heldTime.year  <= wrData;
      endcase
    end else if (strobes.trackEn) begin
      heldTime <= liveTime;
    end
  end

endmodule

// File: rtl/rtcStoreArray.sv
`timescale 1ns/1ps
module rtcStoreArray #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/bcdRtcRam.sv
`timescale 1ns/1ps
module bcdRtcRam
  import rtcPkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int RAM_DEPTH = 256,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              powerGood,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  ctrlStrobes_t      strobes;
  logic [7:0]        wrData, ctrlReg, ramRd, rtcRd;
  logic [RAM_AW-1:0] wrAddrLow;
  calTime_t          liveTime, heldTime;
  logic              readEn, rdRtc;

  rtcBusCtrl #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) ctrlU (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .addr(addr), .ceN(ceN),
    .weN(weN), .dataIn(dataIn), .strobes(strobes), .wrData(wrData),
    .wrAddrLow(wrAddrLow), .ctrlReg(ctrlReg)
  );

  rtcTimeCore coreU (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .strobes(strobes),
    .wrData(wrData), .liveTime(liveTime), .heldTime(heldTime)
  );

  rtcStoreArray #(.DEPTH(RAM_DEPTH)) storeU (
    .clk(clk), .we(strobes.ramWe), .wrAddr(wrAddrLow), .wrData(wrData),
    .rdAddr(addr[RAM_AW-1:0]), .rdData(ramRd)
  );

  assign readEn = !ceN && !oeN && weN && powerGood;
  assign rdRtc  = &addr[ADDR_W-1:3];

  always_comb begin
    case (addr[2:0])
      3'd0:    rtcRd = ctrlReg;
      3'd1:    rtcRd = heldTime.sec;
      3'd2:    rtcRd = heldTime.min;
      3'd3:    rtcRd = heldTime.hour;
      3'd4:    rtcRd = heldTime.day;
      3'd5:    rtcRd = heldTime.date;
      3'd6:    rtcRd = heldTime.month;
      default: rtcRd = heldTime.year;
    endcase
  end

  assign dataOe  = readEn;
  assign dataOut = readEn ? (rdRtc ? rtcRd : ramRd) : 8'h00;

endmodule

// File: rtl/bcdRtcRamChecker.sv
`timescale 1ns/1ps
module bcdRtcRamChecker
  import rtcPkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         tick1Hz,
  input logic         powerGood,
  input logic         ceN,
  input logic         oeN,
  input logic         weN,
  input logic [7:0]   dataOut,
  input logic         dataOe,
  input ctrlStrobes_t strobes,
  input logic [7:0]   ctrlReg,
  input calTime_t     liveTime,
  input calTime_t     heldTime
);

  // R10
  power_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |-> (!dataOe && dataOut == 8'h00 && !strobes.ramWe && !strobes.holdWe));

  // R11
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!ceN && !oeN && weN));

  // R3
  idle_counters_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick1Hz && !strobes.loadCnt) |=> $stable(liveTime));

  // R4
  midnight_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick1Hz && !strobes.loadCnt && liveTime.hour == 8'h23 &&
     liveTime.min == 8'h59 && liveTime.sec == 8'h59)
    |=> (liveTime.hour == 8'h00 && liveTime.min == 8'h00 && liveTime.sec == 8'h00));

  // R8
  frozen_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[FREEZE_BIT] && !strobes.holdWe) |=> $stable(heldTime));

  // R9
  staged_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> (liveTime == $past(heldTime)));

endmodule

bind bcdRtcRam bcdRtcRamChecker chkU (
  .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .powerGood(powerGood),
  .ceN(ceN), .oeN(oeN), .weN(weN), .dataOut(dataOut), .dataOe(dataOe),
  .strobes(strobes), .ctrlReg(ctrlReg), .liveTime(liveTime),
  .heldTime(heldTime)
);

// File: tb/bcdRtcRam_test.sv
`timescale 1ns/1ps
module bcdRtcRam_test;

  localparam real HALF = 2.5;
  localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                          A_HOUR = 15'h7FFB, A_DAY = 15'h7FFC, A_DATE = 15'h7FFD,
                          A_MON = 15'h7FFE, A_YEAR = 15'h7FFF;

  logic clk = 1'b0, rstN = 1'b0, tick1Hz = 1'b0, powerGood = 1'b1;
  logic [14:0] addr = '0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] dataIn = '0, dataOut;
  logic dataOe;

  typedef struct {
    string      tag;
    logic [7:0] expData;
    logic       expOe;
  } expItem_t;

  expItem_t sbQ[$];
  event     sampleEv;
  int       checks = 0, fails = 0;
  bit       doneFlag = 1'b0;

  always #(HALF) clk = ~clk;

  bcdRtcRam uut (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .powerGood(powerGood),
    .addr(addr), .ceN(ceN), .oeN(oeN), .weN(weN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // monitor: pops expected items and compares against the pins
  initial begin
    forever begin
      @(sampleEv);
      if (sbQ.size() != 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        checks++;
        if (dataOut !== it.expData || dataOe !== it.expOe) begin
          fails++;
          $display("FAIL %s: got data=%02h oe=%0b, expected data=%02h oe=%0b",
                   it.tag, dataOut, dataOe, it.expData, it.expOe);
        end
      end
    end
  end

  task automatic busWrite(input logic [14:0] a, input logic [7:0] d, input bit endByCe);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0; oeN = 1'b1;
    @(negedge clk);
    @(negedge clk); if (endByCe) ceN = 1'b1; else weN = 1'b1;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic busRead(input logic [14:0] a, input logic [7:0] e, input logic eOe,
                         input string tag);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    sbQ.push_back('{tag: tag, expData: e, expOe: eOe});
    @(posedge clk); #2;
    -> sampleEv;
    #0.1;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic pulseTick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick1Hz = 1'b1;
      @(negedge clk); tick1Hz = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic setTime(input logic [7:0] yr, mo, dt, dy, hr, mi, se);
    busWrite(A_CTRL, 8'h40, 0);
    busWrite(A_SEC, se, 0);  busWrite(A_MIN, mi, 0);  busWrite(A_HOUR, hr, 0);
    busWrite(A_DAY, dy, 0);  busWrite(A_DATE, dt, 0); busWrite(A_MON, mo, 0);
    busWrite(A_YEAR, yr, 0);
    busWrite(A_CTRL, 8'h00, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic monthEnd(input logic [7:0] yr, mo, dt, input logic [7:0] eMo, eDt,
                          input string tag);
    setTime(yr, mo, dt, 8'h03, 8'h23, 8'h59, 8'h59);
    pulseTick(1);
    busRead(A_DATE, eDt, 1'b1, tag);
    busRead(A_MON, eMo, 1'b1, tag);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!doneFlag) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    busRead(A_CTRL, 8'h00, 1'b1, "R12 ctrl");
    busRead(A_SEC,  8'h00, 1'b1, "R12 sec");
    busRead(A_HOUR, 8'h00, 1'b1, "R12 hour");
    busRead(A_DAY,  8'h01, 1'b1, "R12 day");
    busRead(A_DATE, 8'h01, 1'b1, "R12 date");
    busRead(A_MON,  8'h01, 1'b1, "R12 month");
    busRead(A_YEAR, 8'h00, 1'b1, "R12 year");

    // R1 storage, ended by write enable and by chip enable
    busWrite(15'h0000, 8'hA5, 0);
    busWrite(15'h0123, 8'h3C, 1);
    busWrite(15'h7FF7, 8'h5A, 0);
    busRead(15'h0000, 8'hA5, 1'b1, "R1 addr0");
    busRead(15'h0123, 8'h3C, 1'b1, "R1 ce-ended write");
    busRead(15'h7FF7, 8'h5A, 1'b1, "R1 below clock window");

    // R11 write enable overrides output enable
    @(negedge clk); addr = 15'h0040; dataIn = 8'h77; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    sbQ.push_back('{tag: "R11 no drive during write", expData: 8'h00, expOe: 1'b0});
    @(posedge clk); #2; -> sampleEv; #0.1;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
    busRead(15'h0040, 8'h77, 1'b1, "R11 write landed");

    // R3 seconds carry, and no motion without tick
    setTime(8'h24, 8'h06, 8'h10, 8'h02, 8'h08, 8'h00, 8'h58);
    repeat (20) @(negedge clk);
    busRead(A_SEC, 8'h58, 1'b1, "R3 idle no step");
    pulseTick(1);
    busRead(A_SEC, 8'h59, 1'b1, "R3 step");
    pulseTick(1);
    busRead(A_SEC, 8'h00, 1'b1, "R3 sec wrap");
    busRead(A_MIN, 8'h01, 1'b1, "R3 min carry");

    // R4 midnight with day-of-week wrap
    setTime(8'h23, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
    pulseTick(1);
    busRead(A_HOUR, 8'h00, 1'b1, "R4 hour wrap");
    busRead(A_MIN,  8'h00, 1'b1, "R4 min wrap");
    busRead(A_DAY,  8'h01, 1'b1, "R4 day wrap");
    busRead(A_DATE, 8'h16, 1'b1, "R4 date step");

    // R5 30- and 31-day months
    monthEnd(8'h24, 8'h04, 8'h30, 8'h05, 8'h01, "R5 april end");
    monthEnd(8'h24, 8'h05, 8'h30, 8'h05, 8'h31, "R5 may 30 no wrap");
    monthEnd(8'h24, 8'h01, 8'h31, 8'h02, 8'h01, "R5 january end");

    // R6 february and year end
    monthEnd(8'h23, 8'h02, 8'h28, 8'h03, 8'h01, "R6 feb 28 common");
    monthEnd(8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "R6 feb 28 leap");
    monthEnd(8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "R6 feb 29 end");
    monthEnd(8'h00, 8'h02, 8'h28, 8'h02, 8'h29, "R6 year 00 leap");
    monthEnd(8'h99, 8'h12, 8'h31, 8'h01, 8'h01, "R6 year end");
    busRead(A_YEAR, 8'h00, 1'b1, "R6 year wrap");

    // R7 read in the tick cycle
    setTime(8'h24, 8'h03, 8'h01, 8'h05, 8'h10, 8'h00, 8'h10);
    @(negedge clk); addr = A_SEC; ceN = 1'b0; oeN = 1'b0; weN = 1'b1; tick1Hz = 1'b1;
    sbQ.push_back('{tag: "R7 tick-cycle read", expData: 8'h10, expOe: 1'b1});
    @(posedge clk); #2; -> sampleEv; #0.1;
    @(negedge clk); tick1Hz = 1'b0;
    sbQ.push_back('{tag: "R7 next cycle", expData: 8'h11, expOe: 1'b1});
    @(posedge clk); #2; -> sampleEv; #0.1;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;

    // R8 freeze
    setTime(8'h24, 8'h03, 8'h01, 8'h05, 8'h10, 8'h00, 8'h20);
    busWrite(A_CTRL, 8'h80, 0);
    pulseTick(3);
    busRead(A_SEC, 8'h20, 1'b1, "R8 frozen");
    busRead(A_CTRL, 8'h80, 1'b1, "R2 ctrl readback");
    busWrite(A_CTRL, 8'h00, 0);
    busRead(A_SEC, 8'h23, 1'b1, "R8 resumed");

    // R9 time write without staging has no lasting effect
    busWrite(A_SEC, 8'h45, 0);
    busRead(A_SEC, 8'h23, 1'b1, "R9 unstaged write");

    // R10 power-good low
    @(negedge clk); powerGood = 1'b0;
    busRead(15'h0000, 8'h00, 1'b0, "R10 no drive");
    busWrite(15'h0000, 8'hFF, 0);
    busWrite(A_CTRL, 8'h80, 0);
    @(negedge clk); powerGood = 1'b1;
    busRead(15'h0000, 8'hA5, 1'b1, "R10 ram unchanged");
    busRead(A_CTRL, 8'h00, 1'b1, "R10 ctrl unchanged");

    repeat (4) @(negedge clk);
    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule